// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer with Selective Invalidation

This block is a small fully associative cache of page translations for a virtual memory system with 4KB pages. Every translation request first looks here. The block compares the virtual page number, the address-space tag and the virtual-machine tag of the request against all stored entries in parallel. On a hit, it returns the physical page number and the stored attributes in the same cycle. On a miss, it raises a walk request for an external table walker. When that walker finishes, it installs its result through a fill port. A result from a walk that ended in a fault is dropped.

Software-maintained tables go stale, so the block also takes typed invalidation commands. They remove entries in several ways:
- every entry;
- by virtual-machine tag;
- by address-space tag;
- by virtual page, with or without the address-space tag;
- either of the page forms limited to entries that came from a last-level descriptor.

An entry can be marked contiguous. Such an entry covers sixteen adjacent pages that form one aligned 64KB block. Fills that would overlap an existing entry replace it, so at most one entry can ever hit for a given request.

Top module: `tagged_tlb`

## Requirements
- R1: When `lu_valid` is high and a valid entry matches, `lu_hit` is high, `walk_req` is low, and `lu_ppn`, `lu_memtype`, `lu_cache` and `lu_perm` carry that entry's stored values in the same cycle.
- R2: An entry matches only when its VMID equals `lu_vmid`, its page equals `lu_vpn`, and its ASID equals `lu_asid` or its global flag is set. When `lu_valid` is high and no entry matches, `walk_req` is high and `lu_hit` is low.
- R3: A fill with `fl_fault` high changes no entry.
- R4: A contiguous entry ignores page bits [3:0] when matching. It returns `{stored_ppn[PPN_W-1:4], lu_vpn[3:0]}`.
- R5: Invalidate code 0 removes every entry. Code 7 removes nothing.
- R6: Invalidate code 1 removes every entry whose VMID equals `inv_vmid`, and only those.
- R7: Invalidate code 2 removes the non-global entries whose ASID equals `inv_asid`. Global entries survive it.
- R8: Invalidate code 3 removes the entries whose page matches `inv_vpn` and whose ASID equals `inv_asid`, or which are global.
- R9: Invalidate code 4 removes every entry whose page matches `inv_vpn`, whatever its ASID.
- R10: Codes 5 and 6 act as codes 3 and 4 respectively, but only on entries filled with `fl_last` high.
- R11: An invalidation and a lookup in the same cycle are resolved invalidation first. A lookup of an entry being removed misses.
- R12: A fill that overlaps valid entries (same VMID, same ASID or either side global, page equal with bits [3:0] ignored if either side is contiguous) removes all of them. The new entry takes the lowest overlapping slot, so a lookup never hits two entries.
- R13: A fill with no overlap goes to the lowest-numbered invalid slot. When all slots are valid, it goes to the round-robin pointer's slot, and the pointer then advances by one (wrapping). The pointer is 0 after reset.
- R14: After reset no entry is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lu_valid | input | 1 | Lookup request |
| lu_vpn | input | VPN_W | Lookup virtual page number |
| lu_asid | input | ASID_W | Current address-space tag |
| lu_vmid | input | VMID_W | Current virtual-machine tag |
| lu_hit | output | 1 | Lookup hit |
| lu_ppn | output | PPN_W | Translated physical page number |
| lu_memtype | output | 3 | Stored memory type |
| lu_cache | output | 2 | Stored cache policy |
| lu_perm | output | 3 | Stored access permissions |
| walk_req | output | 1 | Miss: table walk needed |
| fl_valid | input | 1 | Fill strobe from walker |
| fl_fault | input | 1 | Walk ended in a fault |
| fl_vpn | input | VPN_W | Fill virtual page number |
| fl_ppn | input | PPN_W | Fill physical page number |
| fl_asid | input | ASID_W | Fill ASID |
| fl_vmid | input | VMID_W | Fill VMID |
| fl_memtype | input | 3 | Fill memory type |
| fl_cache | input | 2 | Fill cache policy |
| fl_perm | input | 3 | Fill permissions |
| fl_global | input | 1 | Entry matches any ASID |
| fl_last | input | 1 | Came from a last-level descriptor |
| fl_contig | input | 1 | Entry covers a 64KB contiguous block |
| inv_valid | input | 1 | Invalidate strobe |
| inv_cmd | input | 3 | Invalidate type code (0..7 as in R5 to R10) |
| inv_vpn | input | VPN_W | Invalidate page number |
| inv_asid | input | ASID_W | Invalidate ASID |
| inv_vmid | input | VMID_W | Invalidate VMID |

## Verification
Lookups are tried with exact tags, with a wrong ASID, with a wrong VMID, and with global entries under a foreign ASID, which separates tag matching from page matching. For every invalidation code, the bench builds a set of entries that differ in exactly one property (ASID, VMID, global, last-level, page) and checks which survive. This shows that each code filters on the right fields. Contiguous lookups at both ends of the 64KB block and just past it expose the masking and the low-bit merge. Fills into a full buffer, into a buffer with one hole, and on top of existing entries tell the round-robin, first-invalid and overlap-replacement paths apart.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

    typedef enum logic [2:0] {
        INV_ALL     = 3'd0,
        INV_VM      = 3'd1,
        INV_ASID    = 3'd2,
        INV_VA      = 3'd3,
        INV_VA_ANY  = 3'd4,
        INV_VAL     = 3'd5,
        INV_VAL_ANY = 3'd6,
        INV_NONE    = 3'd7
    } inv_kind_e;

    localparam int MT_W = 3;
    localparam int CP_W = 2;
    localparam int PM_W = 3;

endpackage

// File: rtl/tlb_entry_match.sv
`timescale 1ns/1ps
module tlb_entry_match
    import tlb_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int VMID_W = 8,
    parameter int SPAN_B = 4
) (
    input  logic              e_valid,
    input  logic [VPN_W-1:0]  e_vpn,
    input  logic [ASID_W-1:0] e_asid,
    input  logic [VMID_W-1:0] e_vmid,
    input  logic              e_global,
    input  logic              e_last,
    input  logic              e_contig,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASID_W-1:0] q_asid,
    input  logic [VMID_W-1:0] q_vmid,
    input  logic              i_valid,
    input  logic [2:0]        i_cmd,
    input  logic [VPN_W-1:0]  i_vpn,
    input  logic [ASID_W-1:0] i_asid,
    input  logic [VMID_W-1:0] i_vmid,
    input  logic [VPN_W-1:0]  f_vpn,
    input  logic [ASID_W-1:0] f_asid,
    input  logic [VMID_W-1:0] f_vmid,
    input  logic              f_global,
    input  logic              f_contig,
    output logic              lk_match,
    output logic              inv_kill,
    output logic              fill_overlap
);

    localparam logic [VPN_W-1:0] COARSE = {{(VPN_W-SPAN_B){1'b1}}, {SPAN_B{1'b0}}};

    logic [VPN_W-1:0] e_mask;
    logic [VPN_W-1:0] f_mask;
    logic             va_inv;
    logic             asid_inv;
    logic             sel;

    always_comb begin
        e_mask   = e_contig ? COARSE : '1;
        f_mask   = (e_contig || f_contig) ? COARSE : '1;

        lk_match = e_valid && (e_vmid == q_vmid)
                && (e_global || (e_asid == q_asid))
                && (((e_vpn ^ q_vpn) & e_mask) == '0);

        va_inv   = ((e_vpn ^ i_vpn) & e_mask) == '0;
        asid_inv = e_global || (e_asid == i_asid);

        unique case (inv_kind_e'(i_cmd))
            INV_ALL:     sel = 1'b1;
            INV_VM:      sel = (e_vmid == i_vmid);
            INV_ASID:    sel = !e_global && (e_asid == i_asid);
            INV_VA:      sel = va_inv && asid_inv;
            INV_VA_ANY:  sel = va_inv;
            INV_VAL:     sel = va_inv && asid_inv && e_last;
            INV_VAL_ANY: sel = va_inv && e_last;
            default:     sel = 1'b0;
        endcase
        inv_kill = i_valid && e_valid && sel;

        fill_overlap = e_valid && (e_vmid == f_vmid)
                    && (e_global || f_global || (e_asid == f_asid))
                    && (((e_vpn ^ f_vpn) & f_mask) == '0);
    end

endmodule

// File: rtl/tlb_victim_sel.sv
`timescale 1ns/1ps
module tlb_victim_sel #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  slot_valid,
    input  logic [N-1:0]  slot_overlap,
    input  logic [IW-1:0] rr_ptr,
    output logic [IW-1:0] victim,
    output logic          use_rr
);

    logic [IW-1:0] ov_idx;
    logic [IW-1:0] free_idx;
    logic          ov_any;
    logic          free_any;

    always_comb begin
        ov_idx   = '0;
        free_idx = '0;
        ov_any   = 1'b0;
        free_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (slot_overlap[i]) begin
                ov_idx = IW'(i);
                ov_any = 1'b1;
            end
            if (!slot_valid[i]) begin
                free_idx = IW'(i);
                free_any = 1'b1;
            end
        end
        if (ov_any) begin
            victim = ov_idx;
            use_rr = 1'b0;
        end else if (free_any) begin
            victim = free_idx;
            use_rr = 1'b0;
        end else begin
            victim = rr_ptr;
            use_rr = 1'b1;
        end
    end

endmodule

// File: rtl/tagged_tlb.sv
`timescale 1ns/1ps
module tagged_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 24,
    parameter int ASID_W  = 8,
    parameter int VMID_W  = 8,
    parameter int SPAN_B  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lu_valid,
    input  logic [VPN_W-1:0]  lu_vpn,
    input  logic [ASID_W-1:0] lu_asid,
    input  logic [VMID_W-1:0] lu_vmid,
    output logic              lu_hit,
    output logic [PPN_W-1:0]  lu_ppn,
    output logic [2:0]        lu_memtype,
    output logic [1:0]        lu_cache,
    output logic [2:0]        lu_perm,
    output logic              walk_req,
    input  logic              fl_valid,
    input  logic              fl_fault,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PPN_W-1:0]  fl_ppn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [VMID_W-1:0] fl_vmid,
    input  logic [2:0]        fl_memtype,
    input  logic [1:0]        fl_cache,
    input  logic [2:0]        fl_perm,
    input  logic              fl_global,
    input  logic              fl_last,
    input  logic              fl_contig,
    input  logic              inv_valid,
    input  logic [2:0]        inv_cmd,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VMID_W-1:0] inv_vmid
);

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IW-1:0] RR_LAST = IW'(ENTRIES - 1);

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic [VMID_W-1:0] vmid;
        logic [MT_W-1:0]   mt;
        logic [CP_W-1:0]   cp;
        logic [PM_W-1:0]   pm;
        logic              glb;
        logic              last;
        logic              contig;
    } entry_t;

    typedef struct packed {
        logic [ENTRIES-1:0]         valid;
        entry_t [ENTRIES-1:0]       ent;
        logic [IW-1:0]              rr;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] kill_vec;
    logic [ENTRIES-1:0] ovl_raw;
    logic [ENTRIES-1:0] ovl_vec;
    logic [ENTRIES-1:0] valid_eff;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] valid_q;
    logic [IW-1:0]      victim;
    logic               use_rr;
    logic               fill_ok;
    entry_t             rd_ent;
    entry_t             new_ent;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            tlb_entry_match #(
                .VPN_W (VPN_W),
                .ASID_W(ASID_W),
                .VMID_W(VMID_W),
                .SPAN_B(SPAN_B)
            ) u_match (
                .e_valid     (st_q.valid[g]),
                .e_vpn       (st_q.ent[g].vpn),
                .e_asid      (st_q.ent[g].asid),
                .e_vmid      (st_q.ent[g].vmid),
                .e_global    (st_q.ent[g].glb),
                .e_last      (st_q.ent[g].last),
                .e_contig    (st_q.ent[g].contig),
                .q_vpn       (lu_vpn),
                .q_asid      (lu_asid),
                .q_vmid      (lu_vmid),
                .i_valid     (inv_valid),
                .i_cmd       (inv_cmd),
                .i_vpn       (inv_vpn),
                .i_asid      (inv_asid),
                .i_vmid      (inv_vmid),
                .f_vpn       (fl_vpn),
                .f_asid      (fl_asid),
                .f_vmid      (fl_vmid),
                .f_global    (fl_global),
                .f_contig    (fl_contig),
                .lk_match    (match_vec[g]),
                .inv_kill    (kill_vec[g]),
                .fill_overlap(ovl_raw[g])
            );
        end
    endgenerate

    // invalidation is applied before both the lookup and the fill
    assign valid_eff = st_q.valid & ~kill_vec;
    assign ovl_vec   = ovl_raw & ~kill_vec;
    assign hit_vec   = match_vec & ~kill_vec;
    assign valid_q   = st_q.valid;

    tlb_victim_sel #(
        .N (ENTRIES),
        .IW(IW)
    ) u_victim (
        .slot_valid  (valid_eff),
        .slot_overlap(ovl_vec),
        .rr_ptr      (st_q.rr),
        .victim      (victim),
        .use_rr      (use_rr)
    );

    // read side: one-hot AND-OR selection of the hitting entry
    always_comb begin
        rd_ent = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                rd_ent = rd_ent | st_q.ent[i];
            end
        end
        lu_hit     = lu_valid && (|hit_vec);
        walk_req   = lu_valid && !(|hit_vec);
        lu_ppn     = rd_ent.contig ? {rd_ent.ppn[PPN_W-1:SPAN_B], lu_vpn[SPAN_B-1:0]}
                                   : rd_ent.ppn;
        lu_memtype = rd_ent.mt;
        lu_cache   = rd_ent.cp;
        lu_perm    = rd_ent.pm;
    end

    // next-state computation
    always_comb begin
        fill_ok        = fl_valid && !fl_fault;
        new_ent.vpn    = fl_vpn;
        new_ent.ppn    = fl_ppn;
        new_ent.asid   = fl_asid;
        new_ent.vmid   = fl_vmid;
        new_ent.mt     = fl_memtype;
        new_ent.cp     = fl_cache;
        new_ent.pm     = fl_perm;
        new_ent.glb    = fl_global;
        new_ent.last   = fl_last;
        new_ent.contig = fl_contig;

        st_d       = st_q;
        st_d.valid = valid_eff;
        if (fill_ok) begin
            st_d.valid           = valid_eff & ~ovl_vec;
            st_d.valid[victim]   = 1'b1;
            st_d.ent[victim]     = new_ent;
            if (use_rr) begin
                st_d.rr = (st_q.rr == RR_LAST) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tagged_tlb_chk.sv
`timescale 1ns/1ps
module tagged_tlb_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lu_valid,
    input logic         lu_hit,
    input logic         walk_req,
    input logic         fl_valid,
    input logic         fl_fault,
    input logic         inv_valid,
    input logic [2:0]   inv_cmd,
    input logic [N-1:0] hit_vec,
    input logic [N-1:0] valid_q
);

    assert_hit_walk_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lu_hit && walk_req));

    assert_walk_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req || lu_hit) |-> lu_valid);

    assert_single_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_cmd == 3'd0 && !fl_valid) |=> (valid_q == '0));

    assert_fault_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_fault && !inv_valid) |=> (valid_q == $past(valid_q)));

    assert_flush_hides_lookup_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_cmd == 3'd0) |-> !lu_hit);

endmodule

bind tagged_tlb tagged_tlb_chk #(.N(ENTRIES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lu_valid (lu_valid),
    .lu_hit   (lu_hit),
    .walk_req (walk_req),
    .fl_valid (fl_valid),
    .fl_fault (fl_fault),
    .inv_valid(inv_valid),
    .inv_cmd  (inv_cmd),
    .hit_vec  (hit_vec),
    .valid_q  (valid_q)
);

// File: tb/tagged_tlb_tb.sv
`timescale 1ns/1ps
module tagged_tlb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lu_valid = 1'b0;
    logic [19:0] lu_vpn = '0;
    logic [7:0]  lu_asid = '0;
    logic [7:0]  lu_vmid = '0;
    logic        lu_hit;
    logic [23:0] lu_ppn;
    logic [2:0]  lu_memtype;
    logic [1:0]  lu_cache;
    logic [2:0]  lu_perm;
    logic        walk_req;
    logic        fl_valid = 1'b0;
    logic        fl_fault = 1'b0;
    logic [19:0] fl_vpn = '0;
    logic [23:0] fl_ppn = '0;
    logic [7:0]  fl_asid = '0;
    logic [7:0]  fl_vmid = '0;
    logic [2:0]  fl_memtype = '0;
    logic [1:0]  fl_cache = '0;
    logic [2:0]  fl_perm = '0;
    logic        fl_global = 1'b0;
    logic        fl_last = 1'b0;
    logic        fl_contig = 1'b0;
    logic        inv_valid = 1'b0;
    logic [2:0]  inv_cmd = '0;
    logic [19:0] inv_vpn = '0;
    logic [7:0]  inv_asid = '0;
    logic [7:0]  inv_vmid = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    tagged_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .lu_valid(lu_valid), .lu_vpn(lu_vpn), .lu_asid(lu_asid), .lu_vmid(lu_vmid),
        .lu_hit(lu_hit), .lu_ppn(lu_ppn), .lu_memtype(lu_memtype), .lu_cache(lu_cache),
        .lu_perm(lu_perm), .walk_req(walk_req),
        .fl_valid(fl_valid), .fl_fault(fl_fault), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
        .fl_asid(fl_asid), .fl_vmid(fl_vmid), .fl_memtype(fl_memtype), .fl_cache(fl_cache),
        .fl_perm(fl_perm), .fl_global(fl_global), .fl_last(fl_last), .fl_contig(fl_contig),
        .inv_valid(inv_valid), .inv_cmd(inv_cmd), .inv_vpn(inv_vpn),
        .inv_asid(inv_asid), .inv_vmid(inv_vmid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [23:0] ppn,
                        input logic [7:0] asid, input logic [7:0] vmid,
                        input logic g, input logic last, input logic contig,
                        input logic fault);
        @(negedge clk);
        fl_valid = 1'b1; fl_fault = fault; fl_vpn = vpn; fl_ppn = ppn;
        fl_asid = asid; fl_vmid = vmid; fl_global = g; fl_last = last;
        fl_contig = contig;
        @(negedge clk);
        fl_valid = 1'b0; fl_fault = 1'b0;
    endtask

    task automatic inval(input logic [2:0] cmd, input logic [19:0] vpn,
                         input logic [7:0] asid, input logic [7:0] vmid);
        @(negedge clk);
        inv_valid = 1'b1; inv_cmd = cmd; inv_vpn = vpn; inv_asid = asid; inv_vmid = vmid;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic look(input string req, input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [7:0] vmid, input logic exp_hit, input logic [23:0] exp_ppn);
        @(negedge clk);
        lu_valid = 1'b1; lu_vpn = vpn; lu_asid = asid; lu_vmid = vmid;
        #1;
        chk(req, lu_hit, exp_hit);
        chk(req, walk_req, !exp_hit);
        if (exp_hit) chk(req, lu_ppn, exp_ppn);
    endtask

    task automatic t_reset;
        look("R14 reset empty", 20'h12345, 8'd5, 8'd2, 1'b0, '0);
    endtask

    task automatic t_replace;
        for (int i = 0; i < 8; i++)
            fill(20'h01000 + 20'(i), 24'h000500 + 24'(i), 8'd1, 8'd1, 0, 1, 0, 0);
        for (int i = 0; i < 8; i++)
            look("R13 eight fills kept", 20'h01000 + 20'(i), 8'd1, 8'd1, 1'b1, 24'h000500 + 24'(i));
        fill(20'h02000, 24'h000900, 8'd1, 8'd1, 0, 1, 0, 0);
        look("R13 rr evicts slot0", 20'h01000, 8'd1, 8'd1, 1'b0, '0);
        look("R13 new entry", 20'h02000, 8'd1, 8'd1, 1'b1, 24'h000900);
        fill(20'h02001, 24'h000901, 8'd1, 8'd1, 0, 1, 0, 0);
        look("R13 rr evicts slot1", 20'h01001, 8'd1, 8'd1, 1'b0, '0);
        inval(3'd4, 20'h01003, 8'd0, 8'd0);
        fill(20'h02002, 24'h000902, 8'd1, 8'd1, 0, 1, 0, 0);
        look("R13 hole used, slot2 kept", 20'h01002, 8'd1, 8'd1, 1'b1, 24'h000502);
        look("R13 hole fill", 20'h02002, 8'd1, 8'd1, 1'b1, 24'h000902);
    endtask

    task automatic t_hit_tags;
        inval(3'd0, '0, '0, '0);
        fl_memtype = 3'd5; fl_cache = 2'd2; fl_perm = 3'd6;
        fill(20'h12345, 24'hABCDE0, 8'd5, 8'd2, 0, 1, 0, 0);
        fl_memtype = 3'd1; fl_cache = 2'd1; fl_perm = 3'd1;
        look("R1 hit", 20'h12345, 8'd5, 8'd2, 1'b1, 24'hABCDE0);
        chk("R1 memtype", lu_memtype, 3'd5);
        chk("R1 cache", lu_cache, 2'd2);
        chk("R1 perm", lu_perm, 3'd6);
        look("R2 wrong asid", 20'h12345, 8'd6, 8'd2, 1'b0, '0);
        look("R2 wrong vmid", 20'h12345, 8'd5, 8'd3, 1'b0, '0);
        look("R2 wrong page", 20'h12344, 8'd5, 8'd2, 1'b0, '0);
        fill(20'h00222, 24'h000777, 8'd1, 8'd2, 1, 1, 0, 0);
        look("R2 global any asid", 20'h00222, 8'd9, 8'd2, 1'b1, 24'h000777);
        look("R2 global still needs vmid", 20'h00222, 8'd9, 8'd4, 1'b0, '0);
    endtask

    task automatic t_fault;
        fill(20'h00333, 24'h000333, 8'd1, 8'd2, 0, 1, 0, 1);
        look("R3 fault not installed", 20'h00333, 8'd1, 8'd2, 1'b0, '0);
    endtask

    task automatic t_contig;
        inval(3'd0, '0, '0, '0);
        fill(20'h40010, 24'h077770, 8'd1, 8'd1, 0, 1, 1, 0);
        look("R4 contig mid", 20'h4001A, 8'd1, 8'd1, 1'b1, 24'h07777A);
        look("R4 contig low end", 20'h40010, 8'd1, 8'd1, 1'b1, 24'h077770);
        look("R4 contig high end", 20'h4001F, 8'd1, 8'd1, 1'b1, 24'h07777F);
        look("R4 past block", 20'h40020, 8'd1, 8'd1, 1'b0, '0);
    endtask

    task automatic t_all;
        inval(3'd0, '0, '0, '0);
        fill(20'h00010, 24'h10, 8'd1, 8'd1, 0, 1, 0, 0);
        fill(20'h00011, 24'h11, 8'd2, 8'd2, 1, 0, 0, 0);
        fill(20'h00020, 24'h20, 8'd3, 8'd3, 0, 1, 1, 0);
        inval(3'd7, 20'h00010, 8'd1, 8'd1);
        look("R5 code7 keeps a", 20'h00010, 8'd1, 8'd1, 1'b1, 24'h10);
        look("R5 code7 keeps b", 20'h00011, 8'd7, 8'd2, 1'b1, 24'h11);
        inval(3'd0, '0, '0, '0);
        look("R5 all a", 20'h00010, 8'd1, 8'd1, 1'b0, '0);
        look("R5 all b", 20'h00011, 8'd2, 8'd2, 1'b0, '0);
        look("R5 all c", 20'h00021, 8'd3, 8'd3, 1'b0, '0);
    endtask

    task automatic t_vm;
        inval(3'd0, '0, '0, '0);
        fill(20'h00050, 24'h50, 8'd1, 8'd1, 0, 1, 0, 0);
        fill(20'h00050, 24'h51, 8'd1, 8'd2, 0, 1, 0, 0);
        inval(3'd1, '0, '0, 8'd1);
        look("R6 vmid1 gone", 20'h00050, 8'd1, 8'd1, 1'b0, '0);
        look("R6 vmid2 kept", 20'h00050, 8'd1, 8'd2, 1'b1, 24'h51);
    endtask

    task automatic t_asid;
        inval(3'd0, '0, '0, '0);
        fill(20'h00060, 24'h60, 8'd3, 8'd1, 0, 1, 0, 0);
        fill(20'h00061, 24'h61, 8'd3, 8'd1, 1, 1, 0, 0);
        fill(20'h00062, 24'h62, 8'd4, 8'd1, 0, 1, 0, 0);
        inval(3'd2, '0, 8'd3, '0);
        look("R7 asid3 gone", 20'h00060, 8'd3, 8'd1, 1'b0, '0);
        look("R7 global kept", 20'h00061, 8'd3, 8'd1, 1'b1, 24'h61);
        look("R7 asid4 kept", 20'h00062, 8'd4, 8'd1, 1'b1, 24'h62);
    endtask

    task automatic va_setup;
        inval(3'd0, '0, '0, '0);
        fill(20'h00100, 24'hA0, 8'd1, 8'd1, 0, 1, 0, 0);
        fill(20'h00100, 24'hB0, 8'd2, 8'd1, 0, 1, 0, 0);
        fill(20'h00101, 24'hC0, 8'd1, 8'd1, 0, 1, 0, 0);
    endtask

    task automatic t_va;
        va_setup();
        inval(3'd3, 20'h00100, 8'd1, '0);
        look("R8 va+asid gone", 20'h00100, 8'd1, 8'd1, 1'b0, '0);
        look("R8 other asid kept", 20'h00100, 8'd2, 8'd1, 1'b1, 24'hB0);
        look("R8 other page kept", 20'h00101, 8'd1, 8'd1, 1'b1, 24'hC0);
        va_setup();
        inval(3'd4, 20'h00100, 8'd9, '0);
        look("R9 any asid a", 20'h00100, 8'd1, 8'd1, 1'b0, '0);
        look("R9 any asid b", 20'h00100, 8'd2, 8'd1, 1'b0, '0);
        look("R9 other page kept", 20'h00101, 8'd1, 8'd1, 1'b1, 24'hC0);
    endtask

    task automatic t_last;
        inval(3'd0, '0, '0, '0);
        fill(20'h00200, 24'hD0, 8'd1, 8'd1, 0, 0, 0, 0);
        fill(20'h00200, 24'hE0, 8'd2, 8'd1, 0, 1, 0, 0);
        fill(20'h00201, 24'hF0, 8'd1, 8'd1, 0, 1, 0, 0);
        inval(3'd6, 20'h00200, '0, '0);
        look("R10 non-last kept", 20'h00200, 8'd1, 8'd1, 1'b1, 24'hD0);
        look("R10 last gone", 20'h00200, 8'd2, 8'd1, 1'b0, '0);
        inval(3'd5, 20'h00200, 8'd1, '0);
        look("R10 asid form skips non-last", 20'h00200, 8'd1, 8'd1, 1'b1, 24'hD0);
        inval(3'd5, 20'h00201, 8'd1, '0);
        look("R10 asid form last gone", 20'h00201, 8'd1, 8'd1, 1'b0, '0);
    endtask

    task automatic t_same_cycle;
        inval(3'd0, '0, '0, '0);
        fill(20'h00300, 24'h300, 8'd1, 8'd1, 0, 1, 0, 0);
        @(negedge clk);
        inv_valid = 1'b1; inv_cmd = 3'd4; inv_vpn = 20'h00301;
        lu_valid = 1'b1; lu_vpn = 20'h00300; lu_asid = 8'd1; lu_vmid = 8'd1;
        #1;
        chk("R11 unrelated inval keeps hit", lu_hit, 1'b1);
        @(negedge clk);
        inv_vpn = 20'h00300;
        #1;
        chk("R11 same-cycle miss", lu_hit, 1'b0);
        chk("R11 same-cycle walk", walk_req, 1'b1);
        @(negedge clk);
        inv_valid = 1'b0;
        #1;
        chk("R11 stays gone", lu_hit, 1'b0);
    endtask

    task automatic t_overlap;
        inval(3'd0, '0, '0, '0);
        fill(20'h00400, 24'h1, 8'd1, 8'd1, 0, 1, 0, 0);
        fill(20'h00400, 24'h2, 8'd1, 8'd1, 0, 1, 0, 0);
        look("R12 refill replaces", 20'h00400, 8'd1, 8'd1, 1'b1, 24'h2);
        fill(20'h00501, 24'h11, 8'd1, 8'd1, 0, 1, 0, 0);
        fill(20'h00502, 24'h12, 8'd1, 8'd1, 0, 1, 0, 0);
        fill(20'h00500, 24'h900, 8'd1, 8'd1, 0, 1, 1, 0);
        look("R12 contig over pages", 20'h00502, 8'd1, 8'd1, 1'b1, 24'h902);
        look("R12 contig over pages 2", 20'h00501, 8'd1, 8'd1, 1'b1, 24'h901);
        fill(20'h00600, 24'h6, 8'd1, 8'd1, 0, 1, 0, 0);
        fill(20'h00600, 24'h7, 8'd3, 8'd1, 1, 1, 0, 0);
        look("R12 global over asid", 20'h00600, 8'd1, 8'd1, 1'b1, 24'h7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_replace();
        t_hit_tags();
        t_fault();
        t_contig();
        t_all();
        t_vm();
        t_asid();
        t_va();
        t_last();
        t_same_cycle();
        t_overlap();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule